// File: doc/BRIEF.md
# Addressed RGBW packet receiver

This block sits behind a UART byte receiver on a shared RS-485 bus and turns fixed-length colour commands into writes to a 32-entry brightness store. Each packet has ten bytes: a command code, a logical channel number, and then four 16-bit colour values, each sent high byte first. Several boards share one bus. Each board owns eight consecutive logical channels, starting at a channel offset that is set by a parameter. Packets addressed to other boards, or carrying another command code, are consumed and then dropped.

An accepted packet produces four write strobes on consecutive cycles, one for each colour value, in the order the values were received. Before storage the four values are rotated across the group's four raw slots, so that they match the connector wiring. Bytes that the UART flags as overrun are thrown away. An inactivity timer restarts on every good byte. If the bus goes quiet in the middle of a packet, the timer discards the partial packet, which restores packet alignment.

Top module: `rgbw_pkt_rx`

## Requirements
- R1: After reset no write strobe is issued, and the first good byte received is taken as the command byte of a new packet.
- R2: A packet is written only if its first byte is 0x23 and its channel byte lies in the range CH_OFFSET to CH_OFFSET+GROUPS-1 (defaults 8 and 8). Any other packet produces no write strobe at all.
- R3: The write index is (channel − CH_OFFSET)×4 + slot. Received value k (k = 0..3) goes to slot (k+1) mod 4: value 0 to slot 1, value 1 to slot 2, value 2 to slot 3 and value 3 to slot 0.
- R4: Each value is assembled big-endian from two bytes and written unchanged. The four strobes come on four consecutive cycles in received order. The first strobe comes two clock edges after the edge that samples the packet's last byte.
- R5: The byte counter returns to zero after every tenth good byte, whether or not the packet was accepted, so that a following packet sent back to back is framed correctly.
- R6: A good byte that follows the previous good byte within TIMEOUT_CYC clock edges continues the current packet. If TIMEOUT_CYC edges pass with no good byte, the partial packet is discarded and the next good byte starts a new packet.
- R7: A byte presented with the overrun flag set is dropped. It neither advances the byte counter nor restarts the inactivity timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_data | input | 8 | Received byte |
| rx_overrun | input | 1 | Overrun flag qualifying the current byte |
| wr_en | output | 1 | Brightness store write strobe |
| wr_idx | output | 5 | Raw channel index of the write |
| wr_val | output | 16 | Brightness value to store |

## Verification
The checker module checks on every cycle how the byte counter behaves: it wraps after the tenth byte, it is cleared when the timer expires, and it holds on overrun bytes. It also checks the shape of every write burst: exactly four strobes, starting at slot 1 and stepping through the slots of one group, and only after a completed packet. Only the bench scenarios can show the correct data and address: the sweep over every channel byte value, the rejected command codes, the exact boundary of the timeout gap, and recovery after overrun bytes that arrive inside a silent gap.

// File: rtl/rgbw_pkt_pkg.sv
package rgbw_pkt_pkg;
  // raw slot for received colour value k: rotated by one position
  function automatic int unsigned lane_slot(int unsigned k, int unsigned lanes);
    return (k + 1) % lanes;
  endfunction
endpackage

// File: rtl/rgbw_idle_timer.sv
module rgbw_idle_timer #(
  parameter int TIMEOUT_CYC = 32000
) (
  input  logic clk,
  input  logic rst,
  input  logic byte_ok,
  output logic expire
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] TMAX  = TW'(TIMEOUT_CYC);
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst)                 idle_q <= TMAX;
    else if (byte_ok)        idle_q <= '0;
    else if (idle_q != TMAX) idle_q <= idle_q + 1'b1;
  end

  assign expire = !byte_ok && (idle_q == TLAST);
endmodule

// File: rtl/rgbw_framer.sv
module rgbw_framer #(
  parameter int          VAL_W     = 16,
  parameter int          LANES     = 4,
  parameter int          GROUPS    = 8,
  parameter int          CH_OFFSET = 8,
  parameter logic [7:0]  CMD_CODE  = 8'h23,
  localparam int BPV       = VAL_W / 8,
  localparam int PKT_BYTES = 2 + LANES * BPV,
  localparam int CW        = $clog2(PKT_BYTES),
  localparam int GW        = $clog2(GROUPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_ok,
  input  logic [7:0]       byte_data,
  input  logic             expire,
  output logic [CW-1:0]    byte_cnt,
  output logic             pkt_go,
  output logic [GW-1:0]    pkt_grp,
  output logic [VAL_W-1:0] pkt_val [LANES]
);
  localparam logic [CW-1:0] LAST = CW'(PKT_BYTES - 1);

  logic [CW-1:0]    cnt_q;
  logic             cmd_ok_q, chan_ok_q, go_q;
  logic [GW-1:0]    grp_q;
  logic [VAL_W-1:0] val_q [LANES];
  logic             chan_in_range;
  logic [7:0]       chan_rel;

  assign chan_in_range = (int'(byte_data) >= CH_OFFSET) &&
                         (int'(byte_data) <  CH_OFFSET + GROUPS);
  assign chan_rel = byte_data - 8'(CH_OFFSET);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      cmd_ok_q  <= 1'b0;
      chan_ok_q <= 1'b0;
      grp_q     <= '0;
      go_q      <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (expire) begin
        cnt_q <= '0;
      end else if (byte_ok) begin
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == '0) cmd_ok_q <= (byte_data == CMD_CODE);
        if (cnt_q == CW'(1)) begin
          chan_ok_q <= chan_in_range;
          grp_q     <= chan_rel[GW-1:0];
        end
        if (cnt_q == LAST) go_q <= cmd_ok_q && chan_ok_q;
      end
    end
  end

  // big-endian assembly: each lane shifts in its bytes high first
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [CW-1:0] FIRST = CW'(2 + l * BPV);
    localparam logic [CW-1:0] FINAL = CW'(2 + l * BPV + BPV - 1);
    always_ff @(posedge clk) begin
      if (rst) val_q[l] <= '0;
      else if (byte_ok && !expire && cnt_q >= FIRST && cnt_q <= FINAL)
        val_q[l] <= {val_q[l][VAL_W-9:0], byte_data};
    end
    assign pkt_val[l] = val_q[l];
  end

  assign byte_cnt = cnt_q;
  assign pkt_go   = go_q;
  assign pkt_grp  = grp_q;
endmodule

// File: rtl/rgbw_wr_drain.sv
module rgbw_wr_drain
  import rgbw_pkt_pkg::*;
#(
  parameter int VAL_W  = 16,
  parameter int LANES  = 4,
  parameter int GROUPS = 8,
  localparam int GW = $clog2(GROUPS),
  localparam int LW = $clog2(LANES),
  localparam int IW = GW + LW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [GW-1:0]    grp,
  input  logic [VAL_W-1:0] vals [LANES],
  output logic             wr_en,
  output logic [IW-1:0]    wr_idx,
  output logic [VAL_W-1:0] wr_val
);
  logic [VAL_W-1:0] buf_q [LANES];
  logic [GW-1:0]    grp_q;
  logic [LW-1:0]    k_q;
  logic             busy_q;

  function automatic logic [LW-1:0] slot_of(logic [LW-1:0] k);
    return LW'(lane_slot(int'(k), LANES));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en  <= 1'b0;
      wr_idx <= '0;
      wr_val <= '0;
      grp_q  <= '0;
      k_q    <= '0;
      busy_q <= 1'b0;
    end else if (go) begin
      wr_en  <= 1'b1;
      wr_idx <= {grp, slot_of('0)};
      wr_val <= vals[0];
      grp_q  <= grp;
      k_q    <= LW'(1);
      busy_q <= (LANES > 1);
    end else if (busy_q) begin
      wr_en  <= 1'b1;
      wr_idx <= {grp_q, slot_of(k_q)};
      wr_val <= buf_q[k_q];
      k_q    <= k_q + 1'b1;
      busy_q <= (k_q != LW'(LANES - 1));
    end else begin
      wr_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (go) buf_q <= vals;
  end
endmodule

// File: rtl/rgbw_pkt_rx.sv
module rgbw_pkt_rx #(
  parameter int         VAL_W       = 16,
  parameter int         LANES       = 4,
  parameter int         GROUPS      = 8,
  parameter int         CH_OFFSET   = 8,
  parameter logic [7:0] CMD_CODE    = 8'h23,
  parameter int         TIMEOUT_CYC = 32000,
  localparam int BPV       = VAL_W / 8,
  localparam int PKT_BYTES = 2 + LANES * BPV,
  localparam int CW        = $clog2(PKT_BYTES),
  localparam int GW        = $clog2(GROUPS),
  localparam int LW        = $clog2(LANES),
  localparam int IW        = GW + LW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_overrun,
  output logic             wr_en,
  output logic [IW-1:0]    wr_idx,
  output logic [VAL_W-1:0] wr_val
);
  logic             byte_ok, expire, pkt_go;
  logic [CW-1:0]    byte_cnt;
  logic [GW-1:0]    pkt_grp;
  logic [VAL_W-1:0] pkt_val [LANES];

  assign byte_ok = rx_valid && !rx_overrun;

  rgbw_idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst(rst), .byte_ok(byte_ok), .expire(expire)
  );

  rgbw_framer #(
    .VAL_W(VAL_W), .LANES(LANES), .GROUPS(GROUPS),
    .CH_OFFSET(CH_OFFSET), .CMD_CODE(CMD_CODE)
  ) u_frm (
    .clk(clk), .rst(rst), .byte_ok(byte_ok), .byte_data(rx_data),
    .expire(expire), .byte_cnt(byte_cnt), .pkt_go(pkt_go),
    .pkt_grp(pkt_grp), .pkt_val(pkt_val)
  );

  rgbw_wr_drain #(.VAL_W(VAL_W), .LANES(LANES), .GROUPS(GROUPS)) u_drn (
    .clk(clk), .rst(rst), .go(pkt_go), .grp(pkt_grp), .vals(pkt_val),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val)
  );
endmodule

// File: rtl/rgbw_pkt_rx_chk.sv
module rgbw_pkt_rx_chk #(
  parameter int IW    = 5,
  parameter int LW    = 2,
  parameter int CW    = 4,
  parameter int LAST  = 9,
  parameter int LANES = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_valid,
  input logic          rx_overrun,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic [CW-1:0] byte_cnt,
  input logic          expire,
  input logic          pkt_go
);
  logic [3:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)        run_q <= '0;
    else if (wr_en) run_q <= run_q + 1'b1;
    else            run_q <= '0;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !wr_en);

  p_go_before_write_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |-> $past(pkt_go));

  p_first_slot_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |-> wr_idx[LW-1:0] == LW'(1));

  p_next_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |->
      (wr_idx[LW-1:0] == LW'($past(wr_idx[LW-1:0]) + 1'b1)) &&
      (wr_idx[IW-1:LW] == $past(wr_idx[IW-1:LW])));

  p_burst_bound_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> run_q < 4'(LANES));

  p_burst_len_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_en) |-> run_q == 4'(LANES));

  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_overrun && byte_cnt == CW'(LAST)) |=> byte_cnt == '0);

  p_timeout_clears_r6: assert property (@(posedge clk) disable iff (rst)
    expire |=> byte_cnt == '0);

  p_overrun_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_overrun && !expire) |=> $stable(byte_cnt));
endmodule

bind rgbw_pkt_rx rgbw_pkt_rx_chk #(
  .IW(IW), .LW(LW), .CW(CW), .LAST(PKT_BYTES - 1), .LANES(LANES)
) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_overrun(rx_overrun),
  .wr_en(wr_en), .wr_idx(wr_idx), .byte_cnt(byte_cnt),
  .expire(expire), .pkt_go(pkt_go)
);

// File: tb/rgbw_pkt_rx_tb.sv
module rgbw_pkt_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OFF = 8;
  localparam int GRP = 8;
  localparam int TO  = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_overrun = 1'b0;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [15:0] wr_val;

  rgbw_pkt_rx #(.CH_OFFSET(OFF), .GROUPS(GRP), .TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_overrun(rx_overrun), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          nlog = 0;
  int          log_idx [1024];
  int          log_val [1024];
  int          log_cyc [1024];
  always @(negedge clk) begin
    if (wr_en && nlog < 1024) begin
      log_idx[nlog] = int'(wr_idx);
      log_val[nlog] = int'(wr_val);
      log_cyc[nlog] = cyc;
      nlog = nlog + 1;
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  int last_cyc = 0;
  logic [15:0] pv [4];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic o);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_overrun = o; last_cyc = cyc;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    rx_valid = 1'b0; rx_overrun = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic set_vals(input int seed);
    for (int k = 0; k < 4; k++) pv[k] = 16'(seed * 521 + k * 4099 + 7);
  endtask

  task automatic send_pkt(input logic [7:0] cmd, input logic [7:0] ch);
    put(cmd, 1'b0);
    put(ch, 1'b0);
    for (int k = 0; k < 4; k++) begin
      put(pv[k][15:8], 1'b0);
      put(pv[k][7:0], 1'b0);
    end
  endtask

  // check the writes logged since 'start' for one packet
  task automatic expect_pkt(input int start, input bit ok, input int ch,
                            input string req, input bit timing);
    int n = nlog - start;
    chk(n == (ok ? 4 : 0), req, n, ok ? 4 : 0);
    if (ok && n == 4) begin
      for (int k = 0; k < 4; k++) begin
        int ei = (ch - OFF) * 4 + (k + 1) % 4;
        chk(log_idx[start+k] == ei, "R3 index", log_idx[start+k], ei);
        chk(log_val[start+k] == int'(pv[k]), "R4 value", log_val[start+k], int'(pv[k]));
        if (timing)
          chk(log_cyc[start+k] == last_cyc + 2 + k, "R4 timing",
              log_cyc[start+k], last_cyc + 2 + k);
      end
    end
  endtask

  bit done = 1'b0;

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(5);
    // R1: quiet after reset, first byte is a command byte
    chk(nlog == 0, "R1 no write after reset", nlog, 0);
    set_vals(1);
    s = nlog; send_pkt(8'h23, 8'd9); idle(8);
    expect_pkt(s, 1'b1, 9, "R1 first packet", 1'b1);

    // R2/R3/R4: sweep every channel byte
    for (int ch = 0; ch < 256; ch++) begin
      set_vals(ch + 3);
      s = nlog; send_pkt(8'h23, 8'(ch)); idle(8);
      expect_pkt(s, (ch >= OFF && ch < OFF + GRP), ch, "R2 channel range", 1'b1);
    end

    // R2: wrong command codes
    for (int c = 0; c < 4; c++) begin
      logic [7:0] bad;
      bad = (c == 0) ? 8'h22 : (c == 1) ? 8'h24 : (c == 2) ? 8'h00 : 8'hA3;
      set_vals(40 + c);
      s = nlog; send_pkt(bad, 8'd10); idle(8);
      expect_pkt(s, 1'b0, 10, "R2 wrong command", 1'b0);
    end

    // R5: rejected then accepted, back to back
    set_vals(60);
    s = nlog; send_pkt(8'h55, 8'd11); send_pkt(8'h23, 8'd12); idle(8);
    expect_pkt(s, 1'b1, 12, "R5 after rejected", 1'b1);
    // R5: two accepted back to back
    set_vals(61);
    s = nlog; send_pkt(8'h23, 8'd13); send_pkt(8'h23, 8'd14); idle(8);
    chk(nlog - s == 8, "R5 two packets", nlog - s, 8);
    if (nlog - s == 8) begin
      chk(log_idx[s] == 21, "R5 first group", log_idx[s], 21);
      chk(log_idx[s+4] == 25, "R5 second group", log_idx[s+4], 25);
    end

    // R6: gap of TO edges inside a packet still continues it
    set_vals(70);
    s = nlog;
    put(8'h23, 1'b0); put(8'd15, 1'b0); put(pv[0][15:8], 1'b0);
    idle(TO - 1);
    put(pv[0][7:0], 1'b0);
    for (int k = 1; k < 4; k++) begin put(pv[k][15:8], 1'b0); put(pv[k][7:0], 1'b0); end
    idle(8);
    expect_pkt(s, 1'b1, 15, "R6 gap at limit", 1'b1);
    // R6: gap of TO+1 edges discards the partial packet
    set_vals(71);
    s = nlog;
    put(8'h23, 1'b0); put(8'd8, 1'b0); put(8'h12, 1'b0); put(8'h34, 1'b0); put(8'h56, 1'b0);
    idle(TO);
    send_pkt(8'h23, 8'd10); idle(8);
    expect_pkt(s, 1'b1, 10, "R6 timeout resync", 1'b1);

    // R7: overrun bytes inside a packet are dropped
    set_vals(80);
    s = nlog;
    put(8'h23, 1'b0); put(8'hEE, 1'b1); put(8'd11, 1'b0);
    for (int k = 0; k < 4; k++) begin
      put(pv[k][15:8], 1'b0); put(8'h23, 1'b1); put(pv[k][7:0], 1'b0);
    end
    idle(8);
    expect_pkt(s, 1'b1, 11, "R7 overrun dropped", 1'b0);
    // R7: overrun bytes in a silent gap do not restart the timer
    set_vals(81);
    s = nlog;
    put(8'h23, 1'b0); put(8'd9, 1'b0); put(8'hAA, 1'b0);
    for (int i = 0; i < 5; i++) begin idle(5); put(8'h23, 1'b1); end
    send_pkt(8'h23, 8'd14); idle(8);
    expect_pkt(s, 1'b1, 14, "R7 overrun no restart", 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule